// File: doc/BRIEF.md
# Two-Master Alternating-Priority Bus Arbiter

This block decides which of two bus masters may drive a shared bus. Each master raises a request line. The arbiter answers with a registered grant line for each master. A master that has been granted keeps the bus for as long as it holds its request. The grant is never withdrawn while the master is still requesting, even if the other master is waiting.

While the bus is idle, the arbiter remembers which master should win the next contested decision. Each completed tenure passes that priority to the other master. A single lone request is served at once, whichever master holds the stored priority.

Each grant also produces a drive-enable output for that master's bus driver. With no grant active, every driver sits in high impedance. All state changes on the rising clock edge. Reset is synchronous and active high.

Top module: `rr2_arbiter`

## Requirements
- R1: While `rst` is high, `gnt` is 2'b00 on the following edge. The first contested decision after reset goes to master 0 (`gnt` = 2'b01).
- R2: From idle (`gnt` = 2'b00), a request from one master alone is granted on the next rising edge, whatever the stored priority. Bit 0 belongs to master 0 and bit 1 to master 1.
- R3: From idle, if both masters request, the master holding the stored priority is granted on the next rising edge.
- R4: A granted master that keeps its request asserted keeps its grant. The other master's request has no effect on `gnt` meanwhile.
- R5: When a granted master drops its request, `gnt` is 2'b00 after the next edge, even if the other master is requesting. Every handover therefore passes through at least one idle cycle.
- R6: Priority passes to master 1 when master 0 ends a tenure, and to master 0 when master 1 ends one. The stored priority persists through any number of idle cycles.
- R7: At most one bit of `gnt` is high in any cycle.
- R8: `drv_en[i]` is high exactly when `gnt[i]` is high. With `gnt` at 2'b00, both drivers are in high impedance (`drv_en` = 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Request lines; bit i belongs to master i |
| gnt | output | 2 | Registered grants, one-hot or zero |
| drv_en | output | 2 | Bus-driver enables; low means high impedance |

## Verification
Two functions can fall in the same clock edge: a release by the owning master and a standing request from the other master. The bench provokes this by holding the waiting master's request high through the owner's release. It expects an idle cycle and then a grant chosen by the newly passed priority, not by the older priority. A second collision pairs a lone request with a stored priority that favours the other master. This proves that the priority only decides contested edges.

// File: rtl/rr2_pkg.sv
package rr2_pkg;
  localparam int N_REQ = 2;

  typedef enum logic [1:0] {
    ST_IDLE_A = 2'b00,  // idle, master 0 favoured
    ST_IDLE_B = 2'b01,  // idle, master 1 favoured
    ST_OWN_A  = 2'b10,  // master 0 owns the bus
    ST_OWN_B  = 2'b11   // master 1 owns the bus
  } arb_state_t;

  function automatic arb_state_t arb_next(arb_state_t cur, logic [N_REQ-1:0] req);
    arb_state_t n;
    case (cur)
      ST_IDLE_A: n = req[0] ? ST_OWN_A : (req[1] ? ST_OWN_B : ST_IDLE_A);
      ST_IDLE_B: n = req[1] ? ST_OWN_B : (req[0] ? ST_OWN_A : ST_IDLE_B);
      ST_OWN_A:  n = req[0] ? ST_OWN_A : ST_IDLE_B;
      ST_OWN_B:  n = req[1] ? ST_OWN_B : ST_IDLE_A;
      default:   n = ST_IDLE_A;
    endcase
    return n;
  endfunction

  function automatic logic [N_REQ-1:0] grant_of(arb_state_t s);
    logic [N_REQ-1:0] g;
    case (s)
      ST_OWN_A: g = 2'b01;
      ST_OWN_B: g = 2'b10;
      default:  g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/rr2_state.sv
module rr2_state
  import rr2_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output arb_state_t       nxt,
  output logic             ev_release
);
  arb_state_t cur;

  always_comb nxt = arb_next(cur, req);

  // owner dropped its request this cycle
  always_comb ev_release = ((cur == ST_OWN_A) && !req[0]) ||
                           ((cur == ST_OWN_B) && !req[1]);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE_A;
    else     cur <= nxt;
  end
endmodule

// File: rtl/rr2_grant_reg.sv
module rr2_grant_reg
  import rr2_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  arb_state_t       nxt,
  output logic [N_REQ-1:0] gnt
);
  always_ff @(posedge clk) begin
    if (rst) gnt <= '0;
    else     gnt <= grant_of(nxt);
  end
endmodule

// File: rtl/rr2_drive_en.sv
module rr2_drive_en
  import rr2_pkg::*;
(
  input  logic [N_REQ-1:0] gnt,
  output logic [N_REQ-1:0] drv_en
);
  for (genvar i = 0; i < N_REQ; i++) begin : g_en
    assign drv_en[i] = gnt[i];
  end
endmodule

// File: rtl/rr2_arbiter.sv
module rr2_arbiter
  import rr2_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt,
  output logic [N_REQ-1:0] drv_en
);
  arb_state_t nxt;
  logic       ev_release;

  rr2_state u_state (
    .clk(clk), .rst(rst), .req(req), .nxt(nxt), .ev_release(ev_release)
  );

  rr2_grant_reg u_gnt (
    .clk(clk), .rst(rst), .nxt(nxt), .gnt(gnt)
  );

  rr2_drive_en u_drv (
    .gnt(gnt), .drv_en(drv_en)
  );
endmodule

// File: rtl/rr2_arbiter_chk.sv
module rr2_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req,
  input logic [1:0] gnt,
  input logic       ev_release
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (gnt == 2'b00)); // R1
  AST_RST_PRIO: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && req == 2'b11) |=> (gnt == 2'b01)); // R1
  AST_LONE_A: assert property (@(posedge clk) disable iff (rst)
    (gnt == 2'b00 && req == 2'b01) |=> (gnt == 2'b01)); // R2
  AST_LONE_B: assert property (@(posedge clk) disable iff (rst)
    (gnt == 2'b00 && req == 2'b10) |=> (gnt == 2'b10)); // R2
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    (gnt[0] && req[0]) |=> gnt[0]); // R4
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    (gnt[1] && req[1]) |=> gnt[1]); // R4
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ev_release |=> (gnt == 2'b00)); // R5
  AST_PASS_TO_B: assert property (@(posedge clk) disable iff (rst)
    ($fell(gnt[0]) && !$past(rst) && req == 2'b11) |=> (gnt == 2'b10)); // R6
  AST_PASS_TO_A: assert property (@(posedge clk) disable iff (rst)
    ($fell(gnt[1]) && !$past(rst) && req == 2'b11) |=> (gnt == 2'b01)); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R7
endmodule

bind rr2_arbiter rr2_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .ev_release(ev_release)
);

// File: tb/tb_rr2_arbiter.sv
`timescale 1ns/1ps
module tb_rr2_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req = 2'b00;
  logic [1:0] gnt;
  logic [1:0] drv_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rr2_arbiter dut (.clk(clk), .rst(rst), .req(req), .gnt(gnt), .drv_en(drv_en));

  // behavioural reference: owner index (-1 none) and favoured index
  int    owner = -1;
  int    favour = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      owner = -1; favour = 0; tag = "R1";
    end else if (owner >= 0) begin
      if (req[owner]) tag = "R4";
      else begin favour = 1 - owner; owner = -1; tag = "R5"; end
    end else if (req == 2'b11) begin
      owner = favour; tag = "R3";
    end else if (req == 2'b01) begin
      owner = 0; tag = "R2";
    end else if (req == 2'b10) begin
      owner = 1; tag = "R2";
    end else tag = "R6";
  end

  task automatic chk(string t, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_gnt();
    return (owner == 0) ? 2'b01 : (owner == 1) ? 2'b10 : 2'b00;
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(tag, gnt, model_gnt());
      chk("R7", {1'b0, $countones(gnt) > 1}, 2'b00);
      chk("R8", drv_en, gnt);
    end
  end

  task automatic step(logic [1:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", gnt, 2'b00);
    chk("R8", drv_en, 2'b00);
    rst = 1'b0;
    step(2'b11); chk("R1", gnt, 2'b01);
    step(2'b11); chk("R4", gnt, 2'b01);
    step(2'b10); chk("R5", gnt, 2'b00);
    chk("R8", drv_en, 2'b00);
    step(2'b11); chk("R6", gnt, 2'b10);
    step(2'b11); chk("R4", gnt, 2'b10);
    step(2'b01); chk("R5", gnt, 2'b00);
    step(2'b11); chk("R6", gnt, 2'b01);
    chk("R8", drv_en, 2'b01);
    step(2'b00); chk("R5", gnt, 2'b00);
    step(2'b01); chk("R2", gnt, 2'b01);
    step(2'b00); chk("R5", gnt, 2'b00);
    step(2'b00); step(2'b00);
    step(2'b11); chk("R6", gnt, 2'b10);
    step(2'b00); chk("R5", gnt, 2'b00);
    step(2'b10); chk("R2", gnt, 2'b10);
    chk("R8", drv_en, 2'b10);
    step(2'b00);
    step(2'b11); chk("R3", gnt, 2'b01);
    // sticky random traffic with occasional reset
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) req[0] = ~req[0];
      if ($urandom_range(0, 3) == 0) req[1] = ~req[1];
      rst = ($urandom_range(0, 199) == 0);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule